// File: doc/BRIEF.md
# Radix-4 Booth Multiplier

This block multiplies two N-bit operands and returns the full 2N-bit product one clock after the operands are presented. It recodes the multiplier into radix-4 digits, and each digit looks at three overlapping multiplier bits. Each digit picks one partial product from zero, plus or minus the multiplicand, and plus or minus twice the multiplicand. It forms a negative row by inverting the bits and adding a 1 at that row's lowest weight. It sign-extends every row to 2N bits, shifts each row two places further left than the row before it, and adds all the rows together.

A mode input selects how both operands are read: as two's-complement values or as unsigned values. For unsigned operands the multiplier gets two zero bits above its top bit, which adds one digit, so N/2+1 rows are summed. For signed operands that extra digit carries no weight and is held idle, so N/2 rows remain. The select lines of every digit are registered together with the product, so a checker or a bench can watch the recoding directly.

Top module: `booth_mul`

## Requirements
- R1: Digit i reads multiplier bits (2i+1, 2i, 2i-1), with bit -1 taken as 0. Digit 0 therefore sees code {x1, x0, 0}.
- R2: The single select of a digit (bit i of `dig_single`) is 1 exactly for the 3-bit codes 001, 010, 101 and 110. The code is written MSB first as (x(2i+1), x(2i), x(2i-1)).
- R3: The double select (bit i of `dig_double`) is 1 exactly for the codes 011 and 100. It is never 1 in the same digit as the single select.
- R4: The negate select (bit i of `dig_neg`) is 1 exactly for the codes 100, 101, 110 and 111.
- R5: In unsigned mode (`signed_mode`=0) the multiplier is extended with two zero bits. Top digit N/2 then has code {0, 0, x(N-1)}, so its single select equals the multiplier MSB and its double and negate selects are 0.
- R6: In signed mode (`signed_mode`=1) all three selects of top digit N/2 are 0, and only digits 0 to N/2-1 contribute.
- R7: In unsigned mode `product` equals the unsigned product of the two operands, which fits in 2N bits without loss.
- R8: In signed mode `product` equals the two's-complement product of the two operands in 2N bits. This includes the case where both operands are the most negative value.
- R9: All outputs are registered with one cycle of latency. A synchronous active-high `rst` clears `product` and all select outputs to 0.
- R10: A zero multiplicand yields a zero product in either mode, for any multiplier, including multipliers whose digits select negative rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| signed_mode | input | 1 | 1: two's-complement operands; 0: unsigned operands |
| mcand | input | N | Multiplicand |
| mplier | input | N | Multiplier, which is recoded into digits |
| product | output | 2N | Registered product |
| dig_single | output | N/2+1 | Registered single select, one bit per digit |
| dig_double | output | N/2+1 | Registered double select, one bit per digit |
| dig_neg | output | N/2+1 | Registered negate select, one bit per digit |

## Verification
The mode bit and the operands are captured at the same clock edge. A change of mode therefore changes the recoding of the top digit and the sign extension of every row in the same cycle. The bench applies identical operands with their MSBs set back to back, first in one mode and then in the other. It checks the product and the top-digit selects of each cycle against that cycle's own mode. It also asserts reset while nonzero operands are held, and expects all outputs to be cleared rather than loaded with a product.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic single;
    logic dbl;
    logic neg;
  } booth_sel_t;

  localparam booth_sel_t SEL_IDLE = '{single: 1'b0, dbl: 1'b0, neg: 1'b0};

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_pkg::*;
(
  input  logic [2:0]  code,
  output booth_sel_t  sel
);

  // code = {x(2i+1), x(2i), x(2i-1)}
  always_comb begin
    sel = SEL_IDLE;
    unique case (code)
      3'b000: sel = '{single: 1'b0, dbl: 1'b0, neg: 1'b0};
      3'b001: sel = '{single: 1'b1, dbl: 1'b0, neg: 1'b0};
      3'b010: sel = '{single: 1'b1, dbl: 1'b0, neg: 1'b0};
      3'b011: sel = '{single: 1'b0, dbl: 1'b1, neg: 1'b0};
      3'b100: sel = '{single: 1'b0, dbl: 1'b1, neg: 1'b1};
      3'b101: sel = '{single: 1'b1, dbl: 1'b0, neg: 1'b1};
      3'b110: sel = '{single: 1'b1, dbl: 1'b0, neg: 1'b1};
      3'b111: sel = '{single: 1'b0, dbl: 1'b0, neg: 1'b1};
      default: sel = SEL_IDLE;
    endcase
  end

endmodule

// File: rtl/booth_pp_sel.sv
module booth_pp_sel
  import booth_pkg::*;
#(
  parameter int N   = 16,
  parameter int IDX = 0
) (
  input  logic [N+1:0]   y_ext,
  input  booth_sel_t     sel,
  output logic [2*N-1:0] row
);

  localparam int PW    = 2 * N;
  localparam int YW    = N + 2;
  localparam int SHIFT = 2 * IDX;

  logic [YW-1:0] mag;
  logic [YW-1:0] inv;
  logic [PW-1:0] ext;
  logic [PW-1:0] carry_in;

  always_comb begin
    if (sel.single)   mag = y_ext;
    else if (sel.dbl) mag = {y_ext[YW-2:0], 1'b0};
    else              mag = '0;
    inv      = sel.neg ? ~mag : mag;
    ext      = {{(PW-YW){inv[YW-1]}}, inv};
    carry_in = {{(PW-1){1'b0}}, sel.neg};
    row      = (ext << SHIFT) + (carry_in << SHIFT);
  end

endmodule

// File: rtl/booth_row_sum.sv
module booth_row_sum #(
  parameter int ROWS = 9,
  parameter int W    = 32
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           total
);

  localparam int LW = (ROWS + 1) / 2;

  logic [LW-1:0][W-1:0] pair;

  generate
    for (genvar p = 0; p < LW; p++) begin : g_pair
      if (2 * p + 1 < ROWS) begin : g_two
        assign pair[p] = rows[2*p] + rows[2*p+1];
      end else begin : g_one
        assign pair[p] = rows[2*p];
      end
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int k = 0; k < LW; k++) total = total + pair[k];
  end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             signed_mode,
  input  logic [N-1:0]     mcand,
  input  logic [N-1:0]     mplier,
  output logic [2*N-1:0]   product,
  output logic [N/2:0]     dig_single,
  output logic [N/2:0]     dig_double,
  output logic [N/2:0]     dig_neg
);

  localparam int D  = N / 2 + 1;
  localparam int PW = 2 * N;
  localparam int XW = N + 3;

  logic [XW-1:0]        x_ext;
  logic [N+1:0]         y_ext;
  booth_sel_t           sel_raw [D];
  booth_sel_t           sel_use [D];
  logic [D-1:0][PW-1:0] rows;
  logic [PW-1:0]        sum;
  logic                 mode_q;

  // R5 / R6: two extra multiplier bits, zero or sign; bit -1 is 0 (R1)
  assign x_ext = {signed_mode ? {2{mplier[N-1]}} : 2'b00, mplier, 1'b0};
  assign y_ext = {signed_mode ? {2{mcand[N-1]}} : 2'b00, mcand};

  generate
    for (genvar i = 0; i < D; i++) begin : g_dig
      booth_digit_enc i_enc (
        .code (x_ext[2*i+2:2*i]),
        .sel  (sel_raw[i])
      );
      if (i == D - 1) begin : g_top
        assign sel_use[i] = signed_mode ? SEL_IDLE : sel_raw[i];
      end else begin : g_body
        assign sel_use[i] = sel_raw[i];
      end
      booth_pp_sel #(.N(N), .IDX(i)) i_sel (
        .y_ext (y_ext),
        .sel   (sel_use[i]),
        .row   (rows[i])
      );
    end
  endgenerate

  booth_row_sum #(.ROWS(D), .W(PW)) i_sum (
    .rows  (rows),
    .total (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      product    <= '0;
      dig_single <= '0;
      dig_double <= '0;
      dig_neg    <= '0;
      mode_q     <= 1'b0;
    end else begin
      product <= sum;
      mode_q  <= signed_mode;
      for (int k = 0; k < D; k++) begin
        dig_single[k] <= sel_use[k].single;
        dig_double[k] <= sel_use[k].dbl;
        dig_neg[k]    <= sel_use[k].neg;
      end
    end
  end

  // Assertions
  generate
    for (genvar a = 0; a < D; a++) begin : g_chk
      p_sel_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(dig_single[a] && dig_double[a]));
    end
  endgenerate

  p_top_idle_r6: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (!dig_single[D-1] && !dig_double[D-1] && !dig_neg[D-1]));

  p_top_msb_r5: assert property (@(posedge clk) disable iff (rst)
    !signed_mode |=> (dig_single[D-1] == $past(mplier[N-1]))
                     && !dig_double[D-1] && !dig_neg[D-1]);

  p_zero_mcand_r10: assert property (@(posedge clk) disable iff (rst)
    (mcand == '0) |=> (product == '0));

  p_unit_mplier_r7: assert property (@(posedge clk) disable iff (rst)
    (!signed_mode && mplier == {{(N-1){1'b0}}, 1'b1})
      |=> (product == {{N{1'b0}}, $past(mcand)}));

  p_neg_one_r8: assert property (@(posedge clk) disable iff (rst)
    (signed_mode && mplier == {N{1'b1}})
      |=> (product == PW'(0) - {{N{$past(mcand[N-1])}}, $past(mcand)}));

endmodule

// File: tb/test_booth_mul.sv
module test_booth_mul;

  localparam int N       = 16;
  localparam int D       = N / 2 + 1;
  localparam int PW      = 2 * N;
  localparam int CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          signed_mode = 1'b0;
  logic [N-1:0]  mcand = '0;
  logic [N-1:0]  mplier = '0;
  logic [PW-1:0] product;
  logic [D-1:0]  dig_single, dig_double, dig_neg;

  int n_chk = 0;
  int n_bad = 0;

  booth_mul #(.N(N)) i_booth_mul (
    .clk(clk), .rst(rst), .signed_mode(signed_mode),
    .mcand(mcand), .mplier(mplier), .product(product),
    .dig_single(dig_single), .dig_double(dig_double), .dig_neg(dig_neg)
  );

  always #(CLK_PER/2) clk = ~clk;

  // {mode, mcand, mplier, expected product}
  localparam logic [64:0] VEC [12] = '{
    {1'b0, 16'h0003, 16'h0005, 32'h0000000F},
    {1'b1, 16'hFFFF, 16'hFFFF, 32'h00000001},
    {1'b0, 16'hFFFF, 16'hFFFF, 32'hFFFE0001},
    {1'b1, 16'h8000, 16'h8000, 32'h40000000},
    {1'b0, 16'h8000, 16'h8000, 32'h40000000},
    {1'b1, 16'h8000, 16'h0001, 32'hFFFF8000},
    {1'b1, 16'h7FFF, 16'h8000, 32'hC0008000},
    {1'b0, 16'h1234, 16'h0000, 32'h00000000},
    {1'b1, 16'hFFFF, 16'h0002, 32'hFFFFFFFE},
    {1'b0, 16'h00FF, 16'h0100, 32'h0000FF00},
    {1'b1, 16'h0000, 16'hAAAA, 32'h00000000},
    {1'b0, 16'h0000, 16'hFFFF, 32'h00000000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    signed_mode = m; mcand = a; mplier = b;
    @(negedge clk);
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic m, input logic [N-1:0] a,
                                            input logic [N-1:0] b);
    logic signed [PW-1:0] sa, sb;
    if (m) begin
      sa = PW'($signed(a));
      sb = PW'($signed(b));
      return PW'(sa * sb);
    end
    return PW'({{N{1'b0}}, a} * {{N{1'b0}}, b});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [2:0] c;
    logic [N-1:0] ra, rb;
    logic rm;
    // R9: reset state with nonzero operands held
    signed_mode = 1'b1; mcand = 16'h7777; mplier = 16'hCCCC;
    repeat (3) @(negedge clk);
    chk("R9 reset product", 64'(product), 64'h0);
    chk("R9 reset selects", 64'({dig_single, dig_double, dig_neg}), 64'h0);
    rst = 1'b0;

    // Vector table: R7, R8, R10
    foreach (VEC[v]) begin
      apply(VEC[v][64], VEC[v][63:48], VEC[v][47:32]);
      chk(VEC[v][64] ? "R8 table product" : "R7 table product",
          64'(product), 64'(VEC[v][31:0]));
    end

    // Encoder, all 8 codes on digit 1 (R2, R3, R4); digit 0 low bit is 0 (R1)
    for (int k = 0; k < 8; k++) begin
      c = 3'(k);
      apply(1'b0, 16'h0001, {12'b0, c, 1'b0});
      chk("R2 single", 64'(dig_single[1]), 64'(c == 1 || c == 2 || c == 5 || c == 6));
      chk("R3 double", 64'(dig_double[1]), 64'(c == 3 || c == 4));
      chk("R4 neg", 64'(dig_neg[1]), 64'(c[2]));
      chk("R1 digit0", 64'({dig_single[0], dig_double[0], dig_neg[0]}),
          64'({1'b0, c[0], c[0]}));
    end

    // Mode switch with identical operands, MSBs set (R5, R6)
    apply(1'b0, 16'h8001, 16'h8003);
    chk("R5 top digit", 64'({dig_single[D-1], dig_double[D-1], dig_neg[D-1]}), 64'b100);
    chk("R7 switch", 64'(product), 64'(ref_mul(1'b0, 16'h8001, 16'h8003)));
    apply(1'b1, 16'h8001, 16'h8003);
    chk("R6 top digit", 64'({dig_single[D-1], dig_double[D-1], dig_neg[D-1]}), 64'b000);
    chk("R8 switch", 64'(product), 64'(ref_mul(1'b1, 16'h8001, 16'h8003)));
    apply(1'b0, 16'h0005, 16'h7FFF);
    chk("R5 top digit msb0", 64'({dig_single[D-1], dig_double[D-1], dig_neg[D-1]}), 64'b000);

    // Random operands in both modes (R7, R8)
    for (int k = 0; k < 600; k++) begin
      rm = k[0];
      ra = N'($urandom);
      rb = N'($urandom);
      if (k % 50 == 3) ra = 16'h8000;
      if (k % 50 == 7) rb = 16'hFFFF;
      apply(rm, ra, rb);
      chk(rm ? "R8 random" : "R7 random", 64'(product), 64'(ref_mul(rm, ra, rb)));
    end

    // Reset while loaded (R9)
    apply(1'b0, 16'hFFFF, 16'hFFFF);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset clears", 64'(product), 64'h0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule